// File: doc/BRIEF.md
# Vector-Loop State Register Unit

This unit holds the architectural state of a hardware vector loop bolted onto a scalar core. It keeps five fields. The ceiling on loop length (`mvl`) can be changed at run time. The active loop length is `vl`. The group size is `sub`: every loop iteration handles one to four elements as a unit. The last two fields, `src` and `dst`, are the positions reached in the source and destination streams. Software reads and writes the fields one at a time through a register port, or all at once as a single 32-bit state word. Every write is checked against the legal range of each field it touches. A write that breaks a rule is dropped, and the unit asks for an illegal-instruction trap.

The vector state works as a sub-program-counter. On the cycle the core saves its program counter on a trap, exception or interrupt, the unit copies the whole live state into a save register. On the cycle the core restores its program counter on trap return, the unit copies the save register back into the live state. The save register can also be read and written through the register port, so a handler can inspect it or rebuild it.

Top module: `vls_unit`

## Requirements
- R1: After reset the fields read as mvl=1, vl=0, sub=1, src=0, dst=0, the save register word reads 0x00000001, and trap_req is 0.
- R2: A write with wr_sel=1 sets mvl when wr_data lies in 1..64. A value of 0, or any value above 64, is rejected.
- R3: A write with wr_sel=2 sets vl when wr_data lies in 0..mvl. A larger value is rejected.
- R4: A write with wr_sel=3 sets the group size when wr_data lies in 1..4. Any other value is rejected. The size is stored as size-1 in word bits [15:14], and wr_sel=3 reads it back as 1..4.
- R5: Writes with wr_sel=4 (src) and wr_sel=5 (dst) accept 0..63 and reject 64 or more.
- R6: An accepted mvl write that is smaller than the current vl lowers vl to the new mvl on the same clock edge. A larger mvl leaves vl as it is.
- R7: A rejected write changes no field of either the live state or the save register. trap_req is 1 for exactly the one cycle after the write's clock edge.
- R8: wr_sel=0 writes and reads the whole live state word: mvl [6:0], vl [13:7], sub-1 [15:14], src [22:16], dst [29:23]. Bits [31:30] read 0. The word is accepted only if bits [31:30] are zero, mvl is 1..64, vl<=mvl, and src and dst are each below 64. wr_sel=7 writes are always rejected, and wr_sel=7 reads 0.
- R9: On the edge where trap_enter is 1, the save register takes the live state. The save register is read as a word with wr_sel=6 / rd_sel=6.
- R10: On the edge where trap_return is 1 and trap_enter is 0, the live state takes the save register's contents.
- R11: In a cycle with trap_enter or trap_return high, the register write is dropped and no trap is requested. trap_enter takes precedence over trap_return.
- R12: A wr_sel=6 write loads the save register under the same legality rules as R8 and leaves the live state untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 word, 1 mvl, 2 vl, 3 sub, 4 src, 5 dst, 6 save word, 7 none |
| wr_data | input | 32 | Write value |
| rd_sel | input | 3 | Read target, same coding as wr_sel |
| rd_data | output | 32 | Read value, combinational from rd_sel and state |
| trap_enter | input | 1 | Core is saving its program counter this cycle |
| trap_return | input | 1 | Core is restoring its program counter this cycle |
| trap_req | output | 1 | One-cycle illegal-instruction trap request |

## Verification
The bench goes after the edges of each range: mvl at 0, 64 and 65; vl at exactly mvl and at mvl+1; group size at 0, 4 and 5; step counters at 63 and 64. A design that got any of these off by one would accept a reserved value or refuse a legal one, and the read-back would show it. Lowering mvl beneath vl must drag vl down with it; a design without the clamp would leave vl above mvl. A whole-word write with a reserved bit set, or with vl above mvl, must leave every field as it was; a design with a partial update would leave a changed field behind. Trap strobes that land together with a write, or with each other, are exercised too; swapping the order of precedence would corrupt the save register or the live state.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int MAX_LEN = 64;
  localparam int FW      = $clog2(MAX_LEN + 1);
  localparam int SUB_MAX = 4;
  localparam int SW      = $clog2(SUB_MAX);
  localparam int WORD_W  = 32;
  localparam int SEL_W   = 3;
  localparam int OFF_VL  = FW;
  localparam int OFF_SUB = 2 * FW;
  localparam int OFF_SRC = 2 * FW + SW;
  localparam int OFF_DST = 3 * FW + SW;
  localparam int USED_W  = 4 * FW + SW;

  typedef enum logic [SEL_W-1:0] {
    SEL_WORD = 3'd0,
    SEL_MVL  = 3'd1,
    SEL_VL   = 3'd2,
    SEL_SUB  = 3'd3,
    SEL_SRC  = 3'd4,
    SEL_DST  = 3'd5,
    SEL_SAVE = 3'd6,
    SEL_NONE = 3'd7
  } vls_sel_e;

  typedef struct packed {
    logic [FW-1:0] dst;
    logic [FW-1:0] src;
    logic [SW-1:0] sub_code;
    logic [FW-1:0] vl;
    logic [FW-1:0] mvl;
  } vls_state_t;

  localparam vls_state_t RESET_STATE = '{dst: '0, src: '0, sub_code: '0, vl: '0, mvl: FW'(1)};

  function automatic logic [WORD_W-1:0] pack_state(vls_state_t s);
    logic [WORD_W-1:0] w;
    w = '0;
    w[OFF_VL-1:0]        = s.mvl;
    w[OFF_SUB-1:OFF_VL]  = s.vl;
    w[OFF_SRC-1:OFF_SUB] = s.sub_code;
    w[OFF_DST-1:OFF_SRC] = s.src;
    w[USED_W-1:OFF_DST]  = s.dst;
    return w;
  endfunction

  function automatic vls_state_t unpack_state(logic [WORD_W-1:0] w);
    vls_state_t s;
    s.mvl      = w[OFF_VL-1:0];
    s.vl       = w[OFF_SUB-1:OFF_VL];
    s.sub_code = w[OFF_SRC-1:OFF_SUB];
    s.src      = w[OFF_DST-1:OFF_SRC];
    s.dst      = w[USED_W-1:OFF_DST];
    return s;
  endfunction

  function automatic logic len_ok(logic [WORD_W-1:0] v);
    return (v >= WORD_W'(1)) && (v <= WORD_W'(MAX_LEN));
  endfunction

  function automatic logic vl_ok(logic [WORD_W-1:0] v, logic [FW-1:0] mvl);
    return v <= WORD_W'(mvl);
  endfunction

  function automatic logic step_ok(logic [WORD_W-1:0] v);
    return v < WORD_W'(MAX_LEN);
  endfunction

  function automatic logic sub_ok(logic [WORD_W-1:0] v);
    return (v >= WORD_W'(1)) && (v <= WORD_W'(SUB_MAX));
  endfunction

  function automatic logic word_ok(logic [WORD_W-1:0] w);
    vls_state_t s;
    s = unpack_state(w);
    return (w[WORD_W-1:USED_W] == '0) && len_ok(WORD_W'(s.mvl)) &&
           vl_ok(WORD_W'(s.vl), s.mvl) && step_ok(WORD_W'(s.src)) &&
           step_ok(WORD_W'(s.dst));
  endfunction

  function automatic logic [SW-1:0] sub_encode(logic [WORD_W-1:0] v);
    logic [WORD_W-1:0] t;
    t = v - WORD_W'(1);
    return t[SW-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] sub_decode(logic [SW-1:0] c);
    return WORD_W'(c) + WORD_W'(1);
  endfunction
endpackage

// File: rtl/vls_write_eval.sv
module vls_write_eval
  import vls_pkg::*;
(
  input  vls_state_t        cur,
  input  logic [SEL_W-1:0]  sel,
  input  logic [WORD_W-1:0] data,
  output vls_state_t        nxt,
  output logic              to_save,
  output logic              legal
);
  always_comb begin
    nxt     = cur;
    to_save = 1'b0;
    legal   = 1'b0;
    case (sel)
      SEL_WORD: begin
        nxt   = unpack_state(data);
        legal = word_ok(data);
      end
      SEL_SAVE: begin
        nxt     = unpack_state(data);
        to_save = 1'b1;
        legal   = word_ok(data);
      end
      SEL_MVL: begin
        legal   = len_ok(data);
        nxt.mvl = data[FW-1:0];
        if (cur.vl > data[FW-1:0]) nxt.vl = data[FW-1:0];
      end
      SEL_VL: begin
        legal  = vl_ok(data, cur.mvl);
        nxt.vl = data[FW-1:0];
      end
      SEL_SUB: begin
        legal        = sub_ok(data);
        nxt.sub_code = sub_encode(data);
      end
      SEL_SRC: begin
        legal   = step_ok(data);
        nxt.src = data[FW-1:0];
      end
      SEL_DST: begin
        legal   = step_ok(data);
        nxt.dst = data[FW-1:0];
      end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/vls_arbiter.sv
module vls_arbiter (
  input  logic wr_en,
  input  logic trap_enter,
  input  logic trap_return,
  input  logic legal,
  output logic ev_enter,
  output logic ev_return,
  output logic ev_write_ok,
  output logic ev_write_bad
);
  logic trap_any;
  always_comb begin
    trap_any     = trap_enter | trap_return;
    ev_enter     = trap_enter;
    ev_return    = trap_return & ~trap_enter;
    ev_write_ok  = wr_en & ~trap_any & legal;
    ev_write_bad = wr_en & ~trap_any & ~legal;
  end
endmodule

// File: rtl/vls_store.sv
module vls_store
  import vls_pkg::*;
#(
  parameter vls_state_t INIT = RESET_STATE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  vls_state_t d,
  output vls_state_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= INIT;
    else if (load) q <= d;
  end
endmodule

// File: rtl/vls_read_mux.sv
module vls_read_mux
  import vls_pkg::*;
(
  input  vls_state_t        live,
  input  vls_state_t        save,
  input  logic [SEL_W-1:0]  sel,
  output logic [WORD_W-1:0] data
);
  always_comb begin
    case (sel)
      SEL_WORD: data = pack_state(live);
      SEL_MVL:  data = WORD_W'(live.mvl);
      SEL_VL:   data = WORD_W'(live.vl);
      SEL_SUB:  data = sub_decode(live.sub_code);
      SEL_SRC:  data = WORD_W'(live.src);
      SEL_DST:  data = WORD_W'(live.dst);
      SEL_SAVE: data = pack_state(save);
      default:  data = '0;
    endcase
  end
endmodule

// File: rtl/vls_unit.sv
module vls_unit
  import vls_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [WORD_W-1:0] rd_data,
  input  logic              trap_enter,
  input  logic              trap_return,
  output logic              trap_req
);
  vls_state_t live_q, save_q, wr_state, live_d, save_d;
  logic       wr_to_save, wr_legal;
  logic       ev_enter, ev_return, ev_write_ok, ev_write_bad;
  logic       ld_live, ld_save;

  vls_write_eval u_eval (
    .cur(live_q), .sel(wr_sel), .data(wr_data),
    .nxt(wr_state), .to_save(wr_to_save), .legal(wr_legal)
  );

  vls_arbiter u_arb (
    .wr_en(wr_en), .trap_enter(trap_enter), .trap_return(trap_return),
    .legal(wr_legal), .ev_enter(ev_enter), .ev_return(ev_return),
    .ev_write_ok(ev_write_ok), .ev_write_bad(ev_write_bad)
  );

  always_comb begin
    ld_live = ev_return | (ev_write_ok & ~wr_to_save);
    ld_save = ev_enter  | (ev_write_ok &  wr_to_save);
    live_d  = ev_return ? save_q : wr_state;
    save_d  = ev_enter  ? live_q : wr_state;
  end

  vls_store #(.INIT(RESET_STATE)) u_live (
    .clk(clk), .rst_n(rst_n), .load(ld_live), .d(live_d), .q(live_q)
  );

  vls_store #(.INIT(RESET_STATE)) u_save (
    .clk(clk), .rst_n(rst_n), .load(ld_save), .d(save_d), .q(save_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) trap_req <= 1'b0;
    else        trap_req <= ev_write_bad;
  end

  vls_read_mux u_rd (
    .live(live_q), .save(save_q), .sel(rd_sel), .data(rd_data)
  );
endmodule

// File: rtl/vls_sva.sv
module vls_sva
  import vls_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       trap_enter,
  input logic       trap_return,
  input logic       trap_req,
  input vls_state_t live,
  input vls_state_t save,
  input logic       ev_enter,
  input logic       ev_return,
  input logic       ev_write_ok,
  input logic       ev_write_bad
);
  a_r2_mvl_range: assert property (@(posedge clk) disable iff (!rst_n)
    (live.mvl >= FW'(1)) && (live.mvl <= FW'(MAX_LEN)));

  a_r3_vl_bound: assert property (@(posedge clk) disable iff (!rst_n)
    live.vl <= live.mvl);

  a_r5_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    (live.src < FW'(MAX_LEN)) && (live.dst < FW'(MAX_LEN)));

  a_r7_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write_bad |=> (trap_req && $stable(live) && $stable(save)));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !$past(ev_write_bad)) |-> 1'b0);

  a_r9_save_copy: assert property (@(posedge clk) disable iff (!rst_n)
    ev_enter |=> (save == $past(live)));

  a_r10_restore: assert property (@(posedge clk) disable iff (!rst_n)
    ev_return |=> (live == $past(save)));

  a_r11_no_write_in_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_enter || trap_return) |-> !(ev_write_ok || ev_write_bad));

  a_r11_no_req_in_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (trap_enter || trap_return)) |=> !trap_req);

  a_r11_enter_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_enter && trap_return) |=> (live == $past(live)));
endmodule

bind vls_unit vls_sva u_sva (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .trap_enter(trap_enter),
  .trap_return(trap_return), .trap_req(trap_req), .live(live_q), .save(save_q),
  .ev_enter(ev_enter), .ev_return(ev_return), .ev_write_ok(ev_write_ok),
  .ev_write_bad(ev_write_bad)
);

// File: tb/vls_unit_test.sv
module vls_unit_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic [2:0]  rd_sel = 3'd0;
  logic [31:0] rd_data;
  logic        trap_enter = 1'b0;
  logic        trap_return = 1'b0;
  logic        trap_req;

  int checks = 0;
  int errors = 0;

  vls_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .trap_enter(trap_enter),
    .trap_return(trap_return), .trap_req(trap_req)
  );

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    int          sel;
    logic [31:0] exp;
    bit          chk_trap;
    bit          exp_trap;
    string       tag;
  } item_t;
  item_t sb[$];

  // reference model: live and saved fields, group size held as 1..4
  int m_mvl = 1, m_vl = 0, m_sub = 1, m_src = 0, m_dst = 0;
  int s_mvl = 1, s_vl = 0, s_sub = 1, s_src = 0, s_dst = 0;

  function automatic logic [31:0] mk_word(int mvl, int vl, int sub, int src, int dst);
    return 32'(mvl) + 32'(vl) * 32'd128 + 32'(sub - 1) * 32'd16384 +
           32'(src) * 32'd65536 + 32'(dst) * 32'd8388608;
  endfunction

  function automatic bit word_legal(logic [31:0] d);
    int mvl = int'(d[6:0]);
    int vl  = int'(d[13:7]);
    return (d[31:30] == 2'b00) && mvl >= 1 && mvl <= 64 && vl <= mvl &&
           int'(d[22:16]) < 64 && int'(d[29:23]) < 64;
  endfunction

  task automatic push_all(string tag, bit bad);
    logic [31:0] v [7];
    v[0] = mk_word(m_mvl, m_vl, m_sub, m_src, m_dst);
    v[1] = 32'(m_mvl); v[2] = 32'(m_vl); v[3] = 32'(m_sub);
    v[4] = 32'(m_src); v[5] = 32'(m_dst);
    v[6] = mk_word(s_mvl, s_vl, s_sub, s_src, s_dst);
    for (int i = 0; i < 8; i++) begin
      item_t it;
      it.sel = i;
      it.exp = (i < 7) ? v[i] : 32'd0;
      it.chk_trap = (i < 2);
      it.exp_trap = (i == 0) ? bad : 1'b0;
      it.tag = tag;
      sb.push_back(it);
    end
    while (sb.size() != 0) @(posedge clk);
  endtask

  task automatic op(bit we, int sel, logic [31:0] d, bit ent, bit ret, string tag);
    bit bad = 1'b0;
    @(negedge clk);
    wr_en = we; wr_sel = 3'(sel); wr_data = d; trap_enter = ent; trap_return = ret;
    @(posedge clk);
    #1;
    wr_en = 1'b0; trap_enter = 1'b0; trap_return = 1'b0;
    if (ent) begin
      s_mvl = m_mvl; s_vl = m_vl; s_sub = m_sub; s_src = m_src; s_dst = m_dst;
    end else if (ret) begin
      m_mvl = s_mvl; m_vl = s_vl; m_sub = s_sub; m_src = s_src; m_dst = s_dst;
    end else if (we) begin
      case (sel)
        0, 6: begin
          if (!word_legal(d)) bad = 1'b1;
          else if (sel == 0) begin
            m_mvl = int'(d[6:0]); m_vl = int'(d[13:7]); m_sub = int'(d[15:14]) + 1;
            m_src = int'(d[22:16]); m_dst = int'(d[29:23]);
          end else begin
            s_mvl = int'(d[6:0]); s_vl = int'(d[13:7]); s_sub = int'(d[15:14]) + 1;
            s_src = int'(d[22:16]); s_dst = int'(d[29:23]);
          end
        end
        1: if (d == 0 || d > 64) bad = 1'b1;
           else begin m_mvl = int'(d); if (m_vl > m_mvl) m_vl = m_mvl; end
        2: if (d > 32'(m_mvl)) bad = 1'b1; else m_vl = int'(d);
        3: if (d < 1 || d > 4) bad = 1'b1; else m_sub = int'(d);
        4: if (d >= 64) bad = 1'b1; else m_src = int'(d);
        5: if (d >= 64) bad = 1'b1; else m_dst = int'(d);
        default: bad = 1'b1;
      endcase
    end
    push_all(tag, bad);
  endtask

  // monitor: pops expected items and compares away from the rising edge
  always @(negedge clk) begin
    if (rst_n && sb.size() != 0) begin
      item_t it;
      it = sb.pop_front();
      rd_sel = 3'(it.sel);
      #1;
      checks++;
      if (rd_data !== it.exp) begin
        errors++;
        $display("FAIL %s: rd_sel=%0d rd_data=0x%08h expected 0x%08h",
                 it.tag, it.sel, rd_data, it.exp);
      end
      if (it.chk_trap) begin
        checks++;
        if (trap_req !== it.exp_trap) begin
          errors++;
          $display("FAIL %s: trap_req=%0b expected %0b (item %0d)",
                   it.tag, trap_req, it.exp_trap, it.sel);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    push_all("R1 reset state", 1'b0);
    op(1, 1, 32'd64, 0, 0, "R2 mvl=64 accepted");
    op(1, 2, 32'd64, 0, 0, "R3 vl=mvl accepted");
    op(1, 1, 32'd0, 0, 0, "R2 R7 mvl=0 rejected");
    op(1, 1, 32'd65, 0, 0, "R2 R7 mvl=65 rejected");
    op(1, 1, 32'h1000_0020, 0, 0, "R2 mvl huge rejected");
    op(1, 1, 32'd10, 0, 0, "R6 mvl below vl clamps");
    op(1, 2, 32'd11, 0, 0, "R3 R7 vl=mvl+1 rejected");
    op(1, 2, 32'd5, 0, 0, "R3 vl=5 accepted");
    op(1, 1, 32'd20, 0, 0, "R6 mvl above vl no clamp");
    op(1, 3, 32'd0, 0, 0, "R4 sub=0 rejected");
    op(1, 3, 32'd5, 0, 0, "R4 sub=5 rejected");
    op(1, 3, 32'd4, 0, 0, "R4 sub=4 accepted");
    op(1, 3, 32'd3, 0, 0, "R4 sub=3 accepted");
    op(1, 4, 32'd63, 0, 0, "R5 src=63 accepted");
    op(1, 4, 32'd64, 0, 0, "R5 src=64 rejected");
    op(1, 5, 32'd7, 0, 0, "R5 dst=7 accepted");
    op(1, 5, 32'd100, 0, 0, "R5 dst=100 rejected");
    op(1, 7, 32'd1, 0, 0, "R8 select 7 rejected");
    op(1, 0, mk_word(40, 33, 2, 12, 50), 0, 0, "R8 word write legal");
    op(1, 0, mk_word(40, 33, 2, 12, 50) | 32'h4000_0000, 0, 0, "R8 reserved bit rejected");
    op(1, 0, mk_word(8, 9, 1, 0, 0), 0, 0, "R8 word vl>mvl rejected");
    op(1, 0, mk_word(0, 0, 1, 0, 0), 0, 0, "R8 word mvl=0 rejected");
    op(0, 0, 32'd0, 1, 0, "R9 trap enter saves state");
    op(1, 0, mk_word(3, 1, 4, 2, 2), 0, 0, "R8 overwrite live in handler");
    op(0, 0, 32'd0, 0, 1, "R10 trap return restores");
    op(1, 1, 32'd2, 1, 0, "R11 write dropped under enter");
    op(1, 3, 32'd9, 0, 1, "R11 bad write dropped under return");
    op(1, 0, mk_word(64, 64, 3, 63, 63), 0, 0, "R8 word at limits");
    op(0, 0, 32'd0, 1, 1, "R11 enter wins over return");
    op(1, 6, mk_word(12, 4, 1, 1, 1), 0, 0, "R12 save write legal");
    op(1, 6, mk_word(12, 13, 1, 1, 1), 0, 0, "R12 save write rejected");
    op(0, 0, 32'd0, 0, 1, "R10 return loads written save");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule